// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Controller

This block gates a set of derived output clocks in response to three active-low requests: a processor-clock stop, a peripheral-bus clock stop and a power-down. All outputs are modelled as phase signals divided down from one fast system clock. The groups are:

- a differential processor pair group, with true and complement outputs and a drive flag;
- a stoppable bus clock group;
- a bus clock group that runs free unless its stoppable bit is set;
- an auxiliary group that only power-down can stop.

Every output stops at a fixed resting level and restarts without short or stretched pulses. A hold decision is only taken on the edge that brings the output to its resting level. Stop requests are sampled on edges of the clock domain they affect. The effective bus stop is the AND of its pin with a software run bit. Power-down either parks the differential pairs at a driven level or releases them to high impedance, depending on a mode input.

Per-output configuration bits do two jobs. Stoppable bits choose between stopping and free running. Enable bits force an output low at all times.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A low level on `cpu_stop_n` is sampled on falling edges of the internal processor clock (the true phase) through two stages. A stoppable, enabled pair freezes on the first rising true edge after the second sample. It is frozen no later than 5 processor half periods after the request, and the true output still falls at least once within the first 2 half periods plus one cycle.
- R2: A pair frozen by the processor stop shows `cpu_t`=1, `cpu_c`=0 and `cpu_drive`=1. An enabled, driven pair always has `cpu_t` different from `cpu_c`.
- R3: A pair whose `cpu_stoppable` bit is 0 keeps toggling while the processor stop is active.
- R4: After `cpu_stop_n` returns high, a frozen pair resumes. The first falling edge of `cpu_t` comes no later than 6 processor half periods plus one cycle after the release.
- R5: The bus stop request is active when `pci_stop_n`=0 or `pci_run_sw`=0. It is sampled on rising bus clock edges. Every enabled `pci_clk` output is then held low from the next falling edge.
- R6: A `pcif_clk` output with its `pcif_stoppable` bit at 0 keeps toggling during a bus stop. With the bit at 1 it is held low like `pci_clk`.
- R7: After the bus stop request clears, a held `pci_clk` output rises again no later than 4 bus half periods plus one cycle later.
- R8: A low level on `pwr_down_n` is sampled on rising edges of the complement processor phase through two stages. Every bus and auxiliary output is then held low from its next falling edge, whatever its stoppable bit.
- R9: During power-down, with `pd_hiz_mode`=0, each enabled pair holds `cpu_t`=1, `cpu_c`=0 and `cpu_drive`=1. With `pd_hiz_mode`=1 it shows `cpu_drive`=0 and both outputs 0.
- R10: An enable bit at 0 forces its output low at once, whatever the stop inputs. For a pair this means `cpu_t`=0, `cpu_c`=0 and `cpu_drive`=1.
- R11: While its enable and drive stay set, each output changes only on its own domain's edge. No high or low phase is shorter than one half period of that domain.
- R12: Reset behaves as follows:
  - During reset all clock outputs are low, except that `cpu_c` is high for enabled pairs, and `cpu_drive` is 1.
  - The auxiliary group toggles whenever it is enabled and power-down is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock from which all outputs are divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Processor clock stop request, active low |
| pci_stop_n | input | 1 | Bus clock stop request pin, active low |
| pwr_down_n | input | 1 | Power-down request, active low |
| pci_run_sw | input | 1 | Software bus run bit; 0 acts as a bus stop |
| pd_hiz_mode | input | 1 | 1 = pairs go high impedance in power-down |
| cpu_stoppable | input | NCPU | Per pair: 1 = stopped by processor stop |
| cpu_en | input | NCPU | Per pair enable; 0 forces both outputs low |
| pcif_stoppable | input | NPCIF | Per free bus output: 1 = stopped by bus stop |
| pci_en | input | NPCI | Per stoppable bus output enable |
| pcif_en | input | NPCIF | Per free bus output enable |
| aux_en | input | NAUX | Per auxiliary output enable |
| cpu_t | output | NCPU | True phase of each differential pair |
| cpu_c | output | NCPU | Complement phase of each differential pair |
| cpu_drive | output | NCPU | 1 = pair driven, 0 = high impedance |
| pci_clk | output | NPCI | Stoppable bus clocks |
| pcif_clk | output | NPCIF | Optionally free-running bus clocks |
| aux_clk | output | NAUX | Auxiliary clocks, stopped only by power-down |

## Verification
The edge-alignment and pulse-width properties assume that enable bits and the high-impedance mode may change at any cycle. They therefore only judge a transition while the enable (and, for pairs, the drive flag) was set both before and after it. Request pins are taken as synchronous to the fast clock, so the sampling properties can tie each sampler change to a domain edge in the cycle before. The stimulus changes every input one nanosecond after a rising edge and keeps the first output of each group enabled, so that the pulse-width monitor can watch those outputs throughout. Configuration changes re-arm that monitor, because a change of mode may legally move a parked output.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

  typedef struct packed {
    logic t;
    logic c;
    logic drv;
  } pair_lvl_t;

  // Levels of one differential pair from its phase and hold state.
  function automatic pair_lvl_t pair_levels(logic ph, logic en, logic stop_hold,
                                            logic pd_hold, logic pd_hiz);
    pair_lvl_t r;
    if (!en)             r = '{t: 1'b0, c: 1'b0, drv: 1'b1};
    else if (pd_hold)    r = pd_hiz ? '{t: 1'b0, c: 1'b0, drv: 1'b0}
                                    : '{t: 1'b1, c: 1'b0, drv: 1'b1};
    else if (stop_hold)  r = '{t: 1'b1, c: 1'b0, drv: 1'b1};
    else                 r = '{t: ph, c: ~ph, drv: 1'b1};
    return r;
  endfunction

  // Single-ended clock that rests low.
  function automatic logic low_rest_level(logic ph, logic en, logic hold);
    return en & ~hold & ph;
  endfunction

endpackage

// File: rtl/clk_phase_gen.sv
`timescale 1ns/1ps
module clk_phase_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(HALF - 1));
  assign rise_ev = wrap & ~ph;   // phase goes high at this edge
  assign fall_ev = wrap & ph;    // phase goes low at this edge

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/req_sampler.sv
`timescale 1ns/1ps
module req_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic req,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sh <= '0;
        else if (ev) sh <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sh <= '0;
        else if (ev) sh <= {sh[STAGES-2:0], req};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int NPCI     = 6,
  parameter int NPCIF    = 2,
  parameter int NAUX     = 4,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 10,
  parameter int AUX_HALF = 6,
  parameter int CPU_SYNC = 2,
  parameter int PCI_SYNC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_down_n,
  input  logic             pci_run_sw,
  input  logic             pd_hiz_mode,
  input  logic [NCPU-1:0]  cpu_stoppable,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic [NPCIF-1:0] pcif_stoppable,
  input  logic [NPCI-1:0]  pci_en,
  input  logic [NPCIF-1:0] pcif_en,
  input  logic [NAUX-1:0]  aux_en,
  output logic [NCPU-1:0]  cpu_t,
  output logic [NCPU-1:0]  cpu_c,
  output logic [NCPU-1:0]  cpu_drive,
  output logic [NPCI-1:0]  pci_clk,
  output logic [NPCIF-1:0] pcif_clk,
  output logic [NAUX-1:0]  aux_clk
);
  // Domain phases and edge events (named for the checker).
  logic cpu_ph, cpu_rise_ev, cpu_fall_ev;
  logic pci_ph, pci_rise_ev, pci_fall_ev;
  logic aux_ph, aux_rise_ev, aux_fall_ev;

  clk_phase_gen #(.HALF(CPU_HALF)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .ph(cpu_ph), .rise_ev(cpu_rise_ev), .fall_ev(cpu_fall_ev));
  clk_phase_gen #(.HALF(PCI_HALF)) u_pci_div (
    .clk(clk), .rst_n(rst_n), .ph(pci_ph), .rise_ev(pci_rise_ev), .fall_ev(pci_fall_ev));
  clk_phase_gen #(.HALF(AUX_HALF)) u_aux_div (
    .clk(clk), .rst_n(rst_n), .ph(aux_ph), .rise_ev(aux_rise_ev), .fall_ev(aux_fall_ev));

  // Qualified requests, active high.
  logic cpu_stop_q, pd_q, pci_stop_q, pci_stop_req;
  assign pci_stop_req = ~(pci_stop_n & pci_run_sw);

  // True falling edge is the complement rising edge: both sample here.
  req_sampler #(.STAGES(CPU_SYNC)) u_cpu_stop_smp (
    .clk(clk), .rst_n(rst_n), .ev(cpu_fall_ev), .req(~cpu_stop_n), .q(cpu_stop_q));
  req_sampler #(.STAGES(CPU_SYNC)) u_pd_smp (
    .clk(clk), .rst_n(rst_n), .ev(cpu_fall_ev), .req(~pwr_down_n), .q(pd_q));
  req_sampler #(.STAGES(PCI_SYNC)) u_pci_stop_smp (
    .clk(clk), .rst_n(rst_n), .ev(pci_rise_ev), .req(pci_stop_req), .q(pci_stop_q));

  // Hold state, updated only on the edge that reaches the resting level.
  logic [NCPU-1:0]  cpu_hold;
  logic             cpu_pd_hold;
  logic [NPCI-1:0]  pci_hold;
  logic [NPCIF-1:0] pcif_hold;
  logic             pci_pd_hold;
  logic             aux_pd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_hold    <= '0;
      cpu_pd_hold <= 1'b0;
    end else if (cpu_rise_ev) begin
      cpu_hold    <= {NCPU{cpu_stop_q}} & cpu_stoppable;
      cpu_pd_hold <= pd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_hold    <= '0;
      pcif_hold   <= '0;
      pci_pd_hold <= 1'b0;
    end else if (pci_fall_ev) begin
      pci_hold    <= {NPCI{pci_stop_q}};
      pcif_hold   <= {NPCIF{pci_stop_q}} & pcif_stoppable;
      pci_pd_hold <= pd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           aux_pd_hold <= 1'b0;
    else if (aux_fall_ev) aux_pd_hold <= pd_q;
  end

  // Output stage.
  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_pair
      pair_lvl_t lv;
      assign lv = pair_levels(cpu_ph, cpu_en[i], cpu_hold[i], cpu_pd_hold, pd_hiz_mode);
      assign cpu_t[i]     = lv.t;
      assign cpu_c[i]     = lv.c;
      assign cpu_drive[i] = lv.drv;
    end
    for (genvar i = 0; i < NPCI; i++) begin : g_pci
      assign pci_clk[i] = low_rest_level(pci_ph, pci_en[i], pci_hold[i] | pci_pd_hold);
    end
    for (genvar i = 0; i < NPCIF; i++) begin : g_pcif
      assign pcif_clk[i] = low_rest_level(pci_ph, pcif_en[i], pcif_hold[i] | pci_pd_hold);
    end
    for (genvar i = 0; i < NAUX; i++) begin : g_aux
      assign aux_clk[i] = low_rest_level(aux_ph, aux_en[i], aux_pd_hold);
    end
  endgenerate
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk #(
  parameter int NCPU = 2,
  parameter int NPCI = 6,
  parameter int NAUX = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_rise_ev,
  input logic            cpu_fall_ev,
  input logic            pci_rise_ev,
  input logic            pci_fall_ev,
  input logic            aux_rise_ev,
  input logic            aux_fall_ev,
  input logic            cpu_stop_q,
  input logic            pd_q,
  input logic            pci_stop_q,
  input logic            pci_stop_n,
  input logic            pci_run_sw,
  input logic            pd_hiz_mode,
  input logic [NCPU-1:0] cpu_en,
  input logic [NCPU-1:0] cpu_t,
  input logic [NCPU-1:0] cpu_c,
  input logic [NCPU-1:0] cpu_drive,
  input logic [NPCI-1:0] pci_en,
  input logic [NPCI-1:0] pci_clk,
  input logic [NAUX-1:0] aux_en,
  input logic [NAUX-1:0] aux_clk
);
  assert_cpu_sample_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_stop_q) |-> $past(cpu_fall_ev)) else $error("cpu stop sampler moved off edge");

  assert_pd_sample_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> $past(cpu_fall_ev)) else $error("power-down sampler moved off edge");

  assert_pci_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pci_rise_ev |=> (pci_stop_q == $past(~(pci_stop_n & pci_run_sw))))
    else $error("bus stop request is not the AND of pin and bit");

  for (genvar i = 0; i < NCPU; i++) begin : g_pair
    assert_pair_opposite_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en[i] && cpu_drive[i]) |-> (cpu_t[i] != cpu_c[i])) else $error("pair not complementary");
    assert_pair_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_drive[i] |-> (pd_hiz_mode && cpu_en[i] && !cpu_t[i] && !cpu_c[i]))
      else $error("undriven pair outside high-impedance power-down");
    assert_pair_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_en[i] |-> (!cpu_t[i] && !cpu_c[i])) else $error("disabled pair not low");
    assert_pair_fall_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en[i] && $past(cpu_en[i]) && cpu_drive[i] && $past(cpu_drive[i]) && $fell(cpu_t[i]))
      |-> $past(cpu_fall_ev)) else $error("true output fell off edge");
  end

  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    assert_pci_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pci_en[i] |-> !pci_clk[i]) else $error("disabled bus clock not low");
    assert_pci_rise_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_en[i] && $past(pci_en[i]) && $rose(pci_clk[i])) |-> $past(pci_rise_ev))
      else $error("bus clock rose off edge");
    assert_pci_fall_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_en[i] && $past(pci_en[i]) && $fell(pci_clk[i])) |-> $past(pci_fall_ev))
      else $error("bus clock fell off edge");
  end

  for (genvar i = 0; i < NAUX; i++) begin : g_aux
    assert_aux_rise_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_en[i] && $past(aux_en[i]) && $rose(aux_clk[i])) |-> $past(aux_rise_ev))
      else $error("aux clock rose off edge");
    assert_aux_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_en[i] && $past(aux_en[i]) && $fell(aux_clk[i])) |-> $past(aux_fall_ev))
      else $error("aux clock fell off edge");
  end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NCPU(NCPU), .NPCI(NPCI), .NAUX(NAUX)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_rise_ev(cpu_rise_ev), .cpu_fall_ev(cpu_fall_ev),
  .pci_rise_ev(pci_rise_ev), .pci_fall_ev(pci_fall_ev),
  .aux_rise_ev(aux_rise_ev), .aux_fall_ev(aux_fall_ev),
  .cpu_stop_q(cpu_stop_q), .pd_q(pd_q), .pci_stop_q(pci_stop_q),
  .pci_stop_n(pci_stop_n), .pci_run_sw(pci_run_sw), .pd_hiz_mode(pd_hiz_mode),
  .cpu_en(cpu_en), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_drive(cpu_drive),
  .pci_en(pci_en), .pci_clk(pci_clk), .aux_en(aux_en), .aux_clk(aux_clk)
);

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  localparam int NCPU = 2, NPCI = 6, NPCIF = 2, NAUX = 4;
  localparam int CH = 2, PH = 10, AH = 6;
  localparam int SETTLE = 100;
  localparam int WIN = 4 * PH + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_down_n = 1'b1;
  logic pci_run_sw = 1'b1, pd_hiz_mode = 1'b0;
  logic [NCPU-1:0]  cpu_stoppable = '1, cpu_en = '1;
  logic [NPCIF-1:0] pcif_stoppable = '0, pcif_en = '1;
  logic [NPCI-1:0]  pci_en = '1;
  logic [NAUX-1:0]  aux_en = '1;
  logic [NCPU-1:0]  cpu_t, cpu_c, cpu_drive;
  logic [NPCI-1:0]  pci_clk;
  logic [NPCIF-1:0] pcif_clk;
  logic [NAUX-1:0]  aux_clk;

  clk_stop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .NPCIF(NPCIF), .NAUX(NAUX),
                  .CPU_HALF(CH), .PCI_HALF(PH), .AUX_HALF(AH)) u_clk_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_down_n(pwr_down_n), .pci_run_sw(pci_run_sw), .pd_hiz_mode(pd_hiz_mode),
    .cpu_stoppable(cpu_stoppable), .cpu_en(cpu_en), .pcif_stoppable(pcif_stoppable),
    .pci_en(pci_en), .pcif_en(pcif_en), .aux_en(aux_en),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_drive(cpu_drive),
    .pci_clk(pci_clk), .pcif_clk(pcif_clk), .aux_clk(aux_clk));

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // R11 pulse-width monitor on the first output of each group.
  bit mon_on = 1'b0;
  int run_t = 1000, run_p = 1000, run_a = 1000;
  logic pv_t = 1'b0, pv_p = 1'b0, pv_a = 1'b0;

  task automatic mon_rearm();
    run_t = 1000; run_p = 1000; run_a = 1000;
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (cpu_t[0] !== pv_t) begin
        chk(run_t >= CH, "R11", "cpu_t[0] phase width", run_t, CH);
        run_t = 1;
      end else run_t++;
      if (pci_clk[0] !== pv_p) begin
        chk(run_p >= PH, "R11", "pci_clk[0] phase width", run_p, PH);
        run_p = 1;
      end else run_p++;
      if (aux_clk[0] !== pv_a) begin
        chk(run_a >= AH, "R11", "aux_clk[0] phase width", run_a, AH);
        run_a = 1;
      end else run_a++;
    end
    pv_t = cpu_t[0]; pv_p = pci_clk[0]; pv_a = aux_clk[0];
  end

  // Observation window results.
  logic [NCPU-1:0]  w_t, w_c, w_d, w_ttog, w_dtog;
  logic [NPCI-1:0]  w_p, w_ptog;
  logic [NPCIF-1:0] w_f, w_ftog;
  logic [NAUX-1:0]  w_a, w_atog;

  task automatic observe(int n);
    @(negedge clk);
    w_t = cpu_t; w_c = cpu_c; w_d = cpu_drive; w_p = pci_clk; w_f = pcif_clk; w_a = aux_clk;
    w_ttog = '0; w_dtog = '0; w_ptog = '0; w_ftog = '0; w_atog = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      w_ttog |= cpu_t ^ w_t;  w_dtog |= cpu_drive ^ w_d;
      w_ptog |= pci_clk ^ w_p; w_ftog |= pcif_clk ^ w_f; w_atog |= aux_clk ^ w_a;
      w_t = cpu_t; w_c = cpu_c; w_d = cpu_drive; w_p = pci_clk; w_f = pcif_clk; w_a = aux_clk;
    end
  endtask

  // Expected levels from the requirements: packs {toggles, t, c, drive}.
  function automatic int exp_pair(int i);
    if (!cpu_en[i])                          return 4'b0001;          // R10
    if (!pwr_down_n)                         return pd_hiz_mode ? 4'b0000 : 4'b0101; // R9
    if (!cpu_stop_n && cpu_stoppable[i])     return 4'b0101;          // R2
    return 4'b1001;                                                   // R3/R4 running
  endfunction

  function automatic bit bus_stop_req();
    return !(pci_stop_n && pci_run_sw);
  endfunction

  task automatic check_window(string tag);
    for (int i = 0; i < NCPU; i++) begin
      int e = exp_pair(i);
      int a;
      string r;
      r = !cpu_en[i] ? "R10" : !pwr_down_n ? "R9" :
          (!cpu_stop_n && cpu_stoppable[i]) ? "R2" : (!cpu_stop_n ? "R3" : "R4");
      if (e[3]) a = {28'd0, w_ttog[i], 2'b00, w_d[i] & ~w_dtog[i]};
      else      a = {28'd0, w_ttog[i], w_t[i], w_c[i], w_d[i]};
      if (e[3]) e = 4'b1001;
      chk(a == e, r, {tag, " pair"}, a, e);
    end
    for (int i = 0; i < NPCI; i++) begin
      bit run = pci_en[i] && pwr_down_n && !bus_stop_req();
      string r = !pci_en[i] ? "R10" : !pwr_down_n ? "R8" : bus_stop_req() ? "R5" : "R7";
      int a = run ? int'(w_ptog[i]) : int'(w_ptog[i] | w_p[i]);
      chk(a == int'(run), r, {tag, " pci_clk"}, a, int'(run));
    end
    for (int i = 0; i < NPCIF; i++) begin
      bit run = pcif_en[i] && pwr_down_n && !(bus_stop_req() && pcif_stoppable[i]);
      string r = !pcif_en[i] ? "R10" : !pwr_down_n ? "R8" : "R6";
      int a = run ? int'(w_ftog[i]) : int'(w_ftog[i] | w_f[i]);
      chk(a == int'(run), r, {tag, " pcif_clk"}, a, int'(run));
    end
    for (int i = 0; i < NAUX; i++) begin
      bit run = aux_en[i] && pwr_down_n;
      string r = !aux_en[i] ? "R10" : !pwr_down_n ? "R8" : "R12";
      int a = run ? int'(w_atog[i]) : int'(w_atog[i] | w_a[i]);
      chk(a == int'(run), r, {tag, " aux_clk"}, a, int'(run));
    end
  endtask

  task automatic episode();
    step();
    cpu_stop_n     = ($urandom % 2) != 0;
    pci_stop_n     = ($urandom % 3) != 0;
    pci_run_sw     = ($urandom % 3) != 0;
    pwr_down_n     = ($urandom % 4) != 0;
    pd_hiz_mode    = ($urandom % 2) != 0;
    cpu_stoppable  = NCPU'($urandom);
    pcif_stoppable = NPCIF'($urandom);
    cpu_en  = NCPU'($urandom % 8 == 0 ? 1 : 3) | NCPU'(1);
    pci_en  = NPCI'($urandom) | NPCI'(1);
    pcif_en = NPCIF'($urandom) | NPCIF'(1);
    aux_en  = NAUX'($urandom) | NAUX'(1);
    mon_rearm();
    repeat (SETTLE) step();
    observe(WIN);
    check_window("random");
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(cpu_t == '0, "R12", "cpu_t in reset", int'(cpu_t), 0);
    chk(cpu_c == '1, "R12", "cpu_c in reset", int'(cpu_c), 3);
    chk(cpu_drive == '1, "R12", "cpu_drive in reset", int'(cpu_drive), 3);
    chk(pci_clk == '0 && pcif_clk == '0 && aux_clk == '0, "R12", "bus/aux in reset",
        int'(pci_clk | pcif_clk | aux_clk), 0);
    step();
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (SETTLE) step();
    observe(WIN);
    check_window("all running");

    // R1: stop latency and the early falling edge
    repeat ($urandom % 5) step();
    cpu_stop_n = 1'b0;
    n = 0;
    for (int k = 0; k < 2 * CH + 1; k++) begin
      @(negedge clk);
      if (!cpu_t[0]) n++;
    end
    chk(n > 0, "R1", "true output low before freeze", n, 1);
    repeat (3 * CH + 2) @(negedge clk);
    observe(4 * CH);
    chk(!w_ttog[0] && w_t[0] && !w_c[0], "R1", "pair frozen within bound",
        int'({w_ttog[0], w_t[0], w_c[0]}), 3'b010);

    // R4: resume latency
    step();
    cpu_stop_n = 1'b1;
    n = 0;
    while (cpu_t[0] && n < 6 * CH + 4) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 6 * CH + 1, "R4", "cycles to first falling true edge", n, 6 * CH + 1);

    // R5/R7: stop by software bit, then release latency
    step();
    pci_run_sw = 1'b0;
    mon_rearm();
    repeat (SETTLE) step();
    observe(WIN);
    check_window("software bus stop");
    step();
    pci_run_sw = 1'b1;
    n = 0;
    while (!pci_clk[0] && n < 4 * PH + 4) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 4 * PH + 1, "R7", "cycles to first bus rise", n, 4 * PH + 1);

    // R9: power-down in both modes, R6 free output during pin stop
    step();
    pwr_down_n = 1'b0; pd_hiz_mode = 1'b1;
    mon_rearm();
    repeat (SETTLE) step();
    observe(WIN);
    check_window("power-down hiz");
    step();
    pd_hiz_mode = 1'b0;
    mon_rearm();
    repeat (SETTLE) step();
    observe(WIN);
    check_window("power-down driven");
    step();
    pwr_down_n = 1'b1; pci_stop_n = 1'b0; pcif_stoppable = 2'b10;
    mon_rearm();
    repeat (SETTLE) step();
    observe(WIN);
    check_window("pin bus stop");

    for (int e = 0; e < 40; e++) episode();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule